// File: doc/BRIEF.md
# I2C Register-Pointer Access Controller

This controller turns the byte-level events of an I2C target front end into accesses to a 64-byte register space. The front end reports start, repeated start and stop conditions. It also reports each address byte with its read/write bit, each byte the host writes, and each byte the host asks to read. The controller keeps a register pointer and holds the register storage. Bytes 0 to 7 hold the clock and control registers. Bytes 8 to 63 are general-purpose RAM.

In a write transfer, the first data byte after the address loads the pointer. Each later byte is stored at the pointer, and the pointer then advances. A repeated start followed by a read address returns bytes from the current pointer. The pointer advances after every byte read or written, and it wraps from the last byte to byte 0. A separate timekeeper port lets the local clock logic update bytes 0 to 7. When a transfer is addressed, bytes 0 to 6 are copied into a snapshot. Reads of those bytes return the snapshot, so a rollover during a burst cannot split the time across two values.

Top module: `i2c_regptr_ctrl`

## Requirements
- R1: An address event whose upper seven bits `addr_byte[7:1]` equal 0x68, received right after a start or repeated start, is acknowledged with a one-cycle `ack` pulse in the following cycle. Bit 0 of the address byte selects a read (1) or a write (0).
- R2: An address event with any other seven-bit address gives no `ack`, and the controller returns to idle. Data bytes that follow it are not acknowledged and are not stored.
- R3: In a write transfer, the first data byte is acknowledged and loads the pointer from its low six bits. Bits 7:6 are ignored.
- R4: Each later data byte in the same write transfer is acknowledged and stored at the pointer, and the pointer then advances by one.
- R5: A repeated start after the pointer write, followed by the matching address with the read bit, makes read requests return bytes starting at the loaded pointer. Each byte appears on `rbyte` with `rvalid` high in the cycle after its request.
- R6: The pointer advances after every byte read or written, and it wraps from 0x3F to 0x00.
- R7: A read transfer that has no pointer write before it begins at the pointer left by the previous access. After reset, the pointer is 0.
- R8: A stop returns the controller to idle. Data bytes that arrive after it are not acknowledged and are not stored.
- R9: When a matching address is accepted, bytes 0 to 6 are captured into a snapshot. Reads of those bytes return the snapshot, even if the timekeeper changes them during the transfer.
- R10: After reset, `ack` and `rvalid` are low and every register byte reads as 0x00.
- R11: A read request outside an addressed read transfer produces no `rvalid`.
- R12: A timekeeper write (`tk_we`) stores `tk_data` at byte `tk_idx` (0 to 7). A later transfer reads the new value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_seen | input | 1 | Start condition detected |
| rstart_seen | input | 1 | Repeated start detected |
| stop_seen | input | 1 | Stop condition detected |
| addr_seen | input | 1 | Address byte received |
| addr_byte | input | 8 | Seven-bit address in bits 7:1; bit 0 is 1 for a read |
| wbyte_seen | input | 1 | Data byte written by the host |
| wbyte | input | 8 | Written data byte |
| rreq | input | 1 | Host requests a data byte |
| tk_we | input | 1 | Timekeeper write strobe |
| tk_idx | input | 3 | Timekeeper byte index |
| tk_data | input | 8 | Timekeeper data |
| ack | output | 1 | Acknowledge pulse for an address or data byte |
| rvalid | output | 1 | Read byte valid |
| rbyte | output | 8 | Read byte |

## Verification
On every cycle, the assertions check four things. Each acknowledge and each read byte must follow an event of the matching kind. A foreign address is never acknowledged. A stop always lands in idle. Every returned byte advances the pointer by exactly one, modulo 64. Other behaviour can only be shown by the bench's transaction scenarios. These are the byte values returned after pointer loads and wraps, the continuation of a read from the previous pointer, the loss of writes after a stop or a foreign address, and the snapshot holding old time values while the timekeeper changes the live bytes.

// File: rtl/i2c_regptr_ctrl.sv
module i2c_regptr_ctrl #(
  parameter logic [6:0] DEV_ADDR = 7'h68,
  parameter int DEPTH = 64,
  parameter int SNAP = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_seen,
  input  logic       rstart_seen,
  input  logic       stop_seen,
  input  logic       addr_seen,
  input  logic [7:0] addr_byte,
  input  logic       wbyte_seen,
  input  logic [7:0] wbyte,
  input  logic       rreq,
  input  logic       tk_we,
  input  logic [2:0] tk_idx,
  input  logic [7:0] tk_data,
  output logic       ack,
  output logic       rvalid,
  output logic [7:0] rbyte
);
  localparam int AW = $clog2(DEPTH);
  localparam int SW = $clog2(SNAP);
  localparam logic [2:0] S_IDLE = 3'd0, S_ADDR = 3'd1, S_PTR = 3'd2,
                         S_WDATA = 3'd3, S_RDATA = 3'd4;

  logic [2:0]    st;
  logic [AW-1:0] ptr;
  logic [7:0]    mem [DEPTH];
  logic [7:0]    shadow [SNAP];

  wire addr_hit = addr_byte[7:1] == DEV_ADDR;
  wire in_snap  = ptr < AW'(SNAP);
  wire [7:0] rd_src = in_snap ? shadow[ptr[SW-1:0]] : mem[ptr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      ptr    <= '0;
      ack    <= 1'b0;
      rvalid <= 1'b0;
      rbyte  <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      for (int i = 0; i < SNAP; i++) shadow[i] <= '0;
    end else begin
      ack    <= 1'b0;
      rvalid <= 1'b0;
      if (tk_we) mem[AW'(tk_idx)] <= tk_data;
      if (stop_seen) begin
        st <= S_IDLE;
      end else if (start_seen || rstart_seen) begin
        st <= S_ADDR;
      end else if (addr_seen && st == S_ADDR) begin
        if (addr_hit) begin
          ack <= 1'b1;
          st  <= addr_byte[0] ? S_RDATA : S_PTR;
          for (int i = 0; i < SNAP; i++) shadow[i] <= mem[i];
        end else begin
          st <= S_IDLE;
        end
      end else if (wbyte_seen && st == S_PTR) begin
        ack <= 1'b1;
        ptr <= wbyte[AW-1:0];
        st  <= S_WDATA;
      end else if (wbyte_seen && st == S_WDATA) begin
        ack      <= 1'b1;
        mem[ptr] <= wbyte;
        ptr      <= ptr + 1'b1;
      end else if (rreq && st == S_RDATA) begin
        rvalid <= 1'b1;
        rbyte  <= rd_src;
        ptr    <= ptr + 1'b1;
      end
    end
  end
endmodule

// File: rtl/i2c_regptr_ctrl_chk.sv
module i2c_regptr_ctrl_chk #(
  parameter logic [6:0] DEV_ADDR = 7'h68,
  parameter int AW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          addr_seen,
  input logic [7:0]    addr_byte,
  input logic          wbyte_seen,
  input logic          rreq,
  input logic          stop_seen,
  input logic          ack,
  input logic          rvalid,
  input logic [2:0]    st,
  input logic [AW-1:0] ptr
);
  AST_ACK_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> $past(addr_seen || wbyte_seen)); // R1
  AST_FOREIGN_NACK: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_seen && addr_byte[7:1] != DEV_ADDR) |=> !ack); // R2
  AST_RVALID_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid |-> $past(rreq)); // R11
  AST_PTR_STEP_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid |-> ptr == AW'($past(ptr) + 1'b1)); // R6
  AST_STOP_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_seen |=> st == 3'd0); // R8
endmodule

bind i2c_regptr_ctrl i2c_regptr_ctrl_chk #(.DEV_ADDR(DEV_ADDR), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr_seen(addr_seen), .addr_byte(addr_byte),
  .wbyte_seen(wbyte_seen), .rreq(rreq), .stop_seen(stop_seen),
  .ack(ack), .rvalid(rvalid), .st(st), .ptr(ptr)
);

// File: tb/i2c_regptr_ctrl_test.sv
`timescale 1ns/1ps
module i2c_regptr_ctrl_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic start_seen = 0, rstart_seen = 0, stop_seen = 0, addr_seen = 0;
  logic wbyte_seen = 0, rreq = 0, tk_we = 0;
  logic [7:0] addr_byte = 0, wbyte = 0, tk_data = 0;
  logic [2:0] tk_idx = 0;
  logic ack, rvalid;
  logic [7:0] rbyte;

  always #4 clk = ~clk;

  i2c_regptr_ctrl uut (
    .clk(clk), .rst_n(rst_n), .start_seen(start_seen), .rstart_seen(rstart_seen),
    .stop_seen(stop_seen), .addr_seen(addr_seen), .addr_byte(addr_byte),
    .wbyte_seen(wbyte_seen), .wbyte(wbyte), .rreq(rreq), .tk_we(tk_we),
    .tk_idx(tk_idx), .tk_data(tk_data), .ack(ack), .rvalid(rvalid), .rbyte(rbyte)
  );

  int compared = 0, mismatched = 0;
  bit finished = 0;
  logic [7:0] mdl [64];
  logic [7:0] msh [7];
  logic [5:0] mptr = 0;
  logic [7:0] exp_q [$];
  string      tag_q [$];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && rvalid) begin
      if (exp_q.size() == 0) check(0, "R11 unexpected rvalid", rbyte, 0);
      else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(rbyte == e, t, rbyte, e);
      end
    end
  end

  task automatic cond(input int kind);
    @(negedge clk);
    case (kind)
      0: start_seen = 1;
      1: rstart_seen = 1;
      default: stop_seen = 1;
    endcase
    @(negedge clk);
    start_seen = 0; rstart_seen = 0; stop_seen = 0;
  endtask

  task automatic addr_ev(input logic [6:0] a, input bit rd, input bit exp_ack, input string req);
    @(negedge clk);
    addr_seen = 1; addr_byte = {a, rd};
    @(negedge clk);
    addr_seen = 0;
    check(ack == exp_ack, req, ack, exp_ack);
    if (exp_ack) for (int i = 0; i < 7; i++) msh[i] = mdl[i];
  endtask

  task automatic wr_ev(input logic [7:0] b, input bit exp_ack, input int use_kind, input string req);
    @(negedge clk);
    wbyte_seen = 1; wbyte = b;
    @(negedge clk);
    wbyte_seen = 0;
    check(ack == exp_ack, req, ack, exp_ack);
    if (use_kind == 1) mptr = b[5:0];
    else if (use_kind == 2) begin mdl[mptr] = b; mptr = mptr + 1; end
  endtask

  task automatic rd_ev(input bit expect_byte, input string req);
    if (expect_byte) begin
      exp_q.push_back(mptr < 7 ? msh[mptr] : mdl[mptr]);
      tag_q.push_back(req);
      mptr = mptr + 1;
    end
    @(negedge clk);
    rreq = 1;
    @(negedge clk);
    rreq = 0;
  endtask

  task automatic tk_write(input logic [2:0] i, input logic [7:0] d);
    @(negedge clk);
    tk_we = 1; tk_idx = i; tk_data = d;
    @(negedge clk);
    tk_we = 0;
    mdl[i] = d;
  endtask

  task automatic set_ptr_then_read(input logic [7:0] p);
    cond(0); addr_ev(7'h68, 0, 1, "R1 write address ack");
    wr_ev(p, 1, 1, "R3 pointer byte ack");
    cond(1); addr_ev(7'h68, 1, 1, "R5 read address ack");
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mdl[i] = 0;
    for (int i = 0; i < 7; i++) msh[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(ack == 0 && rvalid == 0, "R10 outputs low after reset", {ack, rvalid}, 0);
    // R7 R10: read from reset pointer without pointer write
    cond(0); addr_ev(7'h68, 1, 1, "R1 read address ack");
    rd_ev(1, "R7 R10 byte 0 after reset"); rd_ev(1, "R10 byte 1 after reset");
    cond(2);
    // R3 R4: burst write
    cond(0); addr_ev(7'h68, 0, 1, "R1 write address ack");
    wr_ev(8'h10, 1, 1, "R3 pointer load ack");
    wr_ev(8'hA1, 1, 2, "R4 data ack"); wr_ev(8'hA2, 1, 2, "R4 data ack");
    wr_ev(8'hA3, 1, 2, "R4 data ack");
    cond(2);
    // R5: pointer write, repeated start, read
    set_ptr_then_read(8'h10);
    rd_ev(1, "R5 read 0x10"); rd_ev(1, "R5 read 0x11"); rd_ev(1, "R5 read 0x12");
    cond(2);
    // R7: continue from previous pointer
    cond(0); addr_ev(7'h68, 1, 1, "R1 read address ack");
    rd_ev(1, "R7 continued pointer"); cond(2);
    // R6: wrap on write then on read
    cond(0); addr_ev(7'h68, 0, 1, "R1 write address ack");
    wr_ev(8'h3E, 1, 1, "R3 pointer ack");
    wr_ev(8'h11, 1, 2, "R6 write 0x3E"); wr_ev(8'h22, 1, 2, "R6 write 0x3F");
    wr_ev(8'h33, 1, 2, "R6 write wraps to 0x00");
    cond(2);
    set_ptr_then_read(8'h3F);
    rd_ev(1, "R6 read 0x3F"); rd_ev(1, "R6 read wraps to 0x00"); cond(2);
    // R3: upper pointer bits ignored
    set_ptr_then_read(8'hFE);
    rd_ev(1, "R3 pointer 0xFE masks to 0x3E"); cond(2);
    // R2: foreign address
    cond(0); addr_ev(7'h50, 0, 0, "R2 foreign address no ack");
    wr_ev(8'h05, 0, 0, "R2 byte after foreign address no ack");
    wr_ev(8'h77, 0, 0, "R2 byte after foreign address no ack");
    cond(2);
    set_ptr_then_read(8'h05);
    rd_ev(1, "R2 byte 0x05 untouched"); cond(2);
    // R8: writes after stop ignored
    cond(0); addr_ev(7'h68, 0, 1, "R1 write address ack");
    wr_ev(8'h20, 1, 1, "R3 pointer ack");
    cond(2);
    wr_ev(8'h55, 0, 0, "R8 byte after stop no ack");
    set_ptr_then_read(8'h20);
    rd_ev(1, "R8 byte 0x20 untouched"); cond(2);
    // R11: read requests while idle and during write phase
    rd_ev(0, "R11 idle request");
    cond(0); addr_ev(7'h68, 0, 1, "R1 write address ack");
    rd_ev(0, "R11 request in write phase"); cond(2);
    // R9 R12: snapshot during read burst
    tk_write(3'd0, 8'h59); tk_write(3'd1, 8'h59); tk_write(3'd2, 8'h23);
    set_ptr_then_read(8'h00);
    rd_ev(1, "R12 timekeeper byte 0");
    tk_write(3'd0, 8'h00); tk_write(3'd1, 8'h00); tk_write(3'd2, 8'h00);
    rd_ev(1, "R9 snapshot byte 1"); rd_ev(1, "R9 snapshot byte 2");
    cond(2);
    set_ptr_then_read(8'h00);
    rd_ev(1, "R12 new byte 0"); rd_ev(1, "R12 new byte 1"); cond(2);
    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R5 all expected bytes returned", exp_q.size(), 0);
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      compared++; mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule